// File: doc/BRIEF.md
# Load-Use Stall Controller

This block lives in the decode stage of a five-stage in-order pipeline. Each cycle it compares the source register fields of the instruction now being decoded with the destination of the instruction one stage ahead in execute. If that older instruction is a load and its destination register is one of those sources, the loaded value cannot yet be used. The block then holds the fetch side for one cycle and sends an all-zero control bundle into execute.

During that cycle the program counter and the fetch/decode register keep their values. The same instruction is therefore decoded again on the next cycle, and the instruction after it is fetched again. By then the load has reached the memory/writeback boundary, where a forwarding path, which lies outside this block, can supply the value.

A small model of the program-counter register, the fetch/decode register and the control part of the decode/execute register is included, so that the stall can be observed at the ports. Instruction memory is outside the block. It returns the word at the current program counter in the same cycle.

Top module: `ldu_stall_ctrl`

## Requirements
- R1: A stall (`bubble_o` = 1, `pc_we_o` = `fd_we_o` = 0) is raised in the same cycle whenever the execute-stage memory-read flag is 1 and its destination register equals bits [25:21] or bits [20:16] of the instruction held in the fetch/decode register. Otherwise no stall is raised.
- R2: On the clock edge that ends a stall cycle, the decode/execute register loads an all-zero control bundle: memory-read, memory-write and register-write are all 0.
- R3: On the clock edge that ends a stall cycle, neither the program counter nor the fetch/decode register changes.
- R4: A stall lasts exactly one cycle. The cycle after a stall is not stalled by the same load.
- R5: A load whose destination is register 0 never causes a stall.
- R6: In a cycle without a stall, the program counter advances by PC_STEP (4) and the fetch/decode register captures `imem_rdata`.
- R7: While `rst_n` is low at a clock edge, the program counter becomes 0, the fetch/decode register becomes 0, and the decode/execute control bundle becomes all zero.
- R8: Two consecutive instructions that both read a load's destination cause only one stall cycle in total.
- R9: The opcode is bits [31:26]. Opcode 0x23 (load) decodes to memory-read and register-write. Opcode 0x2B (store) decodes to memory-write. Opcode 0x00 (register-register) decodes to register-write. Every other opcode decodes to all zero. The destination carried into execute is bits [20:16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_rdata | input | 32 | Instruction word at the current program counter |
| pc_o | output | 32 | Program counter |
| fd_instr_o | output | 32 | Instruction held in the fetch/decode register |
| pc_we_o | output | 1 | Program-counter write enable |
| fd_we_o | output | 1 | Fetch/decode register write enable |
| bubble_o | output | 1 | Stall: zero the control bundle entering execute |
| dx_mem_read_o | output | 1 | Execute-stage memory-read flag |
| dx_mem_write_o | output | 1 | Execute-stage memory-write flag |
| dx_reg_write_o | output | 1 | Execute-stage register-write flag |
| dx_rt_o | output | 5 | Execute-stage destination register |

## Verification
The following hold on every cycle and are checked continuously:
- A stall never lasts two cycles, and the fetch side stays frozen across a stall.
- A stall always leaves a zero control bundle in execute.
- A stall only occurs while a load with a nonzero destination sits in execute, and the program counter steps otherwise.

Some behaviour needs particular instruction streams and is shown only by the directed scenarios:
- The register-field comparison that decides whether a stall happens at all.
- The single stall for two consecutive users of one load.
- The double stall for a chain of dependent loads.
- The decoded flags of each opcode.
- A reset arriving in the middle of a stall.

// File: rtl/ldu_pkg.sv
// Package: instruction field encodings and the control bundle carried into
// the execute stage, with a decoder from opcode to control bundle.
// Assumes a fixed 32-bit instruction word with the opcode in the top six bits.
package ldu_pkg;

    localparam int OPC_W = 6;

    localparam logic [OPC_W-1:0] OPC_REGREG = 6'h00;
    localparam logic [OPC_W-1:0] OPC_LOAD   = 6'h23;
    localparam logic [OPC_W-1:0] OPC_STORE  = 6'h2B;

    // Control fields that travel with an instruction into execute.
    typedef struct packed {
        logic mem_read;
        logic mem_write;
        logic reg_write;
    } ctrl_t;

    localparam ctrl_t CTRL_NONE = '{mem_read: 1'b0, mem_write: 1'b0, reg_write: 1'b0};

    // Map an opcode to its control bundle; unknown opcodes do nothing.
    function automatic ctrl_t decode_ctrl(input logic [OPC_W-1:0] opc);
        ctrl_t c;
        c = CTRL_NONE;
        case (opc)
            OPC_LOAD:   begin c.mem_read = 1'b1; c.reg_write = 1'b1; end
            OPC_STORE:  begin c.mem_write = 1'b1; end
            OPC_REGREG: begin c.reg_write = 1'b1; end
            default:    c = CTRL_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ldu_hazard_detect.sv
// Module: ldu_hazard_detect
// Compares the destination of the instruction in execute with every source
// field of the instruction in decode, and flags a hazard when the execute
// instruction reads memory. Register 0 is never a hazard.
// Assumes source fields are packed side by side, field 0 in the low bits.
module ldu_hazard_detect #(
    parameter int REG_AW  = 5,
    parameter int NUM_SRC = 2
) (
    input  logic                      ex_mem_read,
    input  logic [REG_AW-1:0]         ex_dst,
    input  logic [NUM_SRC*REG_AW-1:0] id_srcs,
    output logic                      hazard
);

    logic [NUM_SRC-1:0] src_hit;

    // One equality comparator per source field.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_cmp
        assign src_hit[g] = (id_srcs[g*REG_AW +: REG_AW] == ex_dst);
    end

    // A load with a nonzero destination matching any source stalls decode.
    assign hazard = ex_mem_read && (ex_dst != '0) && (|src_hit);

endmodule

// File: rtl/ldu_fetch_stage.sv
// Module: ldu_fetch_stage
// Program counter and fetch/decode instruction register, each with its own
// write enable. Reset clears both.
// Assumes instruction memory answers combinationally for the current PC.
module ldu_fetch_stage #(
    parameter int          XLEN     = 32,
    parameter int          PC_STEP  = 4,
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pc_we,
    input  logic            fd_we,
    input  logic [XLEN-1:0] imem_rdata,
    output logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] fd_instr
);

    localparam logic [XLEN-1:0] STEP  = XLEN'(PC_STEP);
    localparam logic [XLEN-1:0] PC_RV = XLEN'(RESET_PC);

    // Program counter: step forward unless frozen by a stall.
    always_ff @(posedge clk) begin
        if (!rst_n)     pc <= PC_RV;
        else if (pc_we) pc <= pc + STEP;
    end

    // Fetch/decode register: capture the fetched word unless frozen.
    always_ff @(posedge clk) begin
        if (!rst_n)     fd_instr <= '0;
        else if (fd_we) fd_instr <= imem_rdata;
    end

endmodule

// File: rtl/ldu_dx_stage.sv
// Module: ldu_dx_stage
// Control part of the decode/execute register. A bubble replaces the
// decoded bundle with all zeros; reset also leaves all zeros.
// Assumes the destination field is carried even for bubbles (it is harmless
// because memory-read is zero).
module ldu_dx_stage #(
    parameter int REG_AW = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bubble,
    input  ldu_pkg::ctrl_t      ctrl_in,
    input  logic [REG_AW-1:0]   dst_in,
    output ldu_pkg::ctrl_t      ctrl_q,
    output logic [REG_AW-1:0]   dst_q
);

    // Control bundle: zeroed on reset or bubble, else the decoded bundle.
    always_ff @(posedge clk) begin
        if (!rst_n || bubble) ctrl_q <= ldu_pkg::CTRL_NONE;
        else                  ctrl_q <= ctrl_in;
    end

    // Destination register number travelling alongside the bundle.
    always_ff @(posedge clk) begin
        if (!rst_n) dst_q <= '0;
        else        dst_q <= dst_in;
    end

endmodule

// File: rtl/ldu_stall_ctrl.sv
// Module: ldu_stall_ctrl (top)
// Decode-stage load-use stall controller with a model of the PC, the
// fetch/decode register and the decode/execute control register.
// On a hazard it freezes the PC and fetch/decode register for one cycle
// and injects a zero control bundle into execute.
// Assumes the opcode, first source and second source sit at the
// field positions given by the parameters; forwarding is handled elsewhere.
module ldu_stall_ctrl #(
    parameter int XLEN    = 32,
    parameter int REG_AW  = 5,
    parameter int PC_STEP = 4,
    parameter int OPC_LSB = 26,
    parameter int RS_LSB  = 21,
    parameter int RT_LSB  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XLEN-1:0]   imem_rdata,
    output logic [XLEN-1:0]   pc_o,
    output logic [XLEN-1:0]   fd_instr_o,
    output logic              pc_we_o,
    output logic              fd_we_o,
    output logic              bubble_o,
    output logic              dx_mem_read_o,
    output logic              dx_mem_write_o,
    output logic              dx_reg_write_o,
    output logic [REG_AW-1:0] dx_rt_o
);

    import ldu_pkg::*;

    localparam int NUM_SRC = 2;

    logic [XLEN-1:0]           fd_instr;
    logic [XLEN-1:0]           pc;
    logic [OPC_W-1:0]          id_opc;
    logic [REG_AW-1:0]         id_rs;
    logic [REG_AW-1:0]         id_rt;
    logic [NUM_SRC*REG_AW-1:0] id_srcs;
    ctrl_t                     id_ctrl;
    ctrl_t                     dx_ctrl;
    logic [REG_AW-1:0]         dx_rt;
    logic                      stall;

    // Field extraction from the instruction in decode.
    assign id_opc  = fd_instr[OPC_LSB +: OPC_W];
    assign id_rs   = fd_instr[RS_LSB  +: REG_AW];
    assign id_rt   = fd_instr[RT_LSB  +: REG_AW];
    assign id_srcs = {id_rt, id_rs};
    assign id_ctrl = decode_ctrl(id_opc);

    ldu_hazard_detect #(
        .REG_AW  (REG_AW),
        .NUM_SRC (NUM_SRC)
    ) u_hazard (
        .ex_mem_read (dx_ctrl.mem_read),
        .ex_dst      (dx_rt),
        .id_srcs     (id_srcs),
        .hazard      (stall)
    );

    ldu_fetch_stage #(
        .XLEN    (XLEN),
        .PC_STEP (PC_STEP)
    ) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .pc_we      (!stall),
        .fd_we      (!stall),
        .imem_rdata (imem_rdata),
        .pc         (pc),
        .fd_instr   (fd_instr)
    );

    ldu_dx_stage #(
        .REG_AW (REG_AW)
    ) u_dx (
        .clk     (clk),
        .rst_n   (rst_n),
        .bubble  (stall),
        .ctrl_in (id_ctrl),
        .dst_in  (id_rt),
        .ctrl_q  (dx_ctrl),
        .dst_q   (dx_rt)
    );

    // Port mapping.
    assign pc_o           = pc;
    assign fd_instr_o     = fd_instr;
    assign pc_we_o        = !stall;
    assign fd_we_o        = !stall;
    assign bubble_o       = stall;
    assign dx_mem_read_o  = dx_ctrl.mem_read;
    assign dx_mem_write_o = dx_ctrl.mem_write;
    assign dx_reg_write_o = dx_ctrl.reg_write;
    assign dx_rt_o        = dx_rt;

endmodule

// File: rtl/ldu_stall_ctrl_chk.sv
// Module: ldu_stall_ctrl_chk
// Port-level temporal checks for ldu_stall_ctrl, attached with bind.
module ldu_stall_ctrl_chk #(
    parameter int XLEN    = 32,
    parameter int REG_AW  = 5,
    parameter int PC_STEP = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [XLEN-1:0]   pc_o,
    input logic [XLEN-1:0]   fd_instr_o,
    input logic              pc_we_o,
    input logic              fd_we_o,
    input logic              bubble_o,
    input logic              dx_mem_read_o,
    input logic              dx_mem_write_o,
    input logic              dx_reg_write_o,
    input logic [REG_AW-1:0] dx_rt_o
);

    AST_STALL_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_o |-> dx_mem_read_o && (dx_rt_o != '0)); // R1
    AST_ZERO_BUNDLE: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_o |=> !dx_mem_read_o && !dx_mem_write_o && !dx_reg_write_o); // R2
    AST_FETCH_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_o |=> $stable(pc_o) && $stable(fd_instr_o)); // R3
    AST_ENABLES_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we_o == fd_we_o) && (pc_we_o != bubble_o)); // R3
    AST_SINGLE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_o |=> !bubble_o); // R4
    AST_PC_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        !bubble_o |=> pc_o == $past(pc_o) + XLEN'(PC_STEP)); // R6

endmodule

bind ldu_stall_ctrl ldu_stall_ctrl_chk #(
    .XLEN    (XLEN),
    .REG_AW  (REG_AW),
    .PC_STEP (PC_STEP)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .pc_o           (pc_o),
    .fd_instr_o     (fd_instr_o),
    .pc_we_o        (pc_we_o),
    .fd_we_o        (fd_we_o),
    .bubble_o       (bubble_o),
    .dx_mem_read_o  (dx_mem_read_o),
    .dx_mem_write_o (dx_mem_write_o),
    .dx_reg_write_o (dx_reg_write_o),
    .dx_rt_o        (dx_rt_o)
);

// File: tb/ldu_stall_ctrl_tb.sv
`timescale 1ns/1ps
module ldu_stall_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem [0:15];
    logic [31:0] imem_rdata;
    logic [31:0] pc_o, fd_instr_o;
    logic        pc_we_o, fd_we_o, bubble_o;
    logic        dx_mem_read_o, dx_mem_write_o, dx_reg_write_o;
    logic [4:0]  dx_rt_o;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    assign imem_rdata = imem[pc_o[5:2]];

    ldu_stall_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .imem_rdata(imem_rdata),
        .pc_o(pc_o), .fd_instr_o(fd_instr_o), .pc_we_o(pc_we_o),
        .fd_we_o(fd_we_o), .bubble_o(bubble_o),
        .dx_mem_read_o(dx_mem_read_o), .dx_mem_write_o(dx_mem_write_o),
        .dx_reg_write_o(dx_reg_write_o), .dx_rt_o(dx_rt_o)
    );

    function automatic logic [31:0] ld(input logic [4:0] rt, input logic [4:0] rs);
        return {6'h23, rs, rt, 16'h0};
    endfunction
    function automatic logic [31:0] st(input logic [4:0] rt, input logic [4:0] rs);
        return {6'h2B, rs, rt, 16'h0};
    endfunction
    function automatic logic [31:0] rr(input logic [4:0] rd, input logic [4:0] rs, input logic [4:0] rt);
        return {6'h00, rs, rt, rd, 5'h0, 6'h20};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 16; i++) imem[i] = 32'h0;
    endtask

    // Reset, leaving the bench at a falling edge with cycle index 0.
    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Run n cycles; count bubbles seen at indices 0..n-1.
    task automatic count_bubbles(input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            if (bubble_o) cnt++;
            step();
        end
    endtask

    task automatic t_reset_state();
        clear_mem();
        imem[0] = ld(5'd2, 5'd1);
        imem[1] = rr(5'd3, 5'd2, 5'd4);
        do_reset();
        chk("R7 pc", pc_o, 32'h0);
        chk("R7 fd", fd_instr_o, 32'h0);
        chk("R7 ctrl", {dx_mem_read_o, dx_mem_write_o, dx_reg_write_o}, 3'b000);
        chk("R7 bubble", bubble_o, 1'b0);
        step(); step();
        chk("R1 stall before reset", bubble_o, 1'b1);
        rst_n = 1'b0;
        step();
        chk("R7 pc mid-stall", pc_o, 32'h0);
        chk("R7 fd mid-stall", fd_instr_o, 32'h0);
        chk("R7 ctrl mid-stall", {dx_mem_read_o, dx_mem_write_o, dx_reg_write_o}, 3'b000);
        rst_n = 1'b1;
    endtask

    task automatic t_no_hazard();
        clear_mem();
        imem[0] = rr(5'd3, 5'd4, 5'd5);
        imem[1] = st(5'd6, 5'd7);
        imem[2] = ld(5'd8, 5'd1);
        imem[3] = rr(5'd9, 5'd10, 5'd11);
        do_reset();
        for (int n = 1; n <= 5; n++) begin
            step();
            chk("R6 pc step", pc_o, 32'(4 * n));
            chk("R6 fd capture", fd_instr_o, imem[n-1]);
            chk("R5/R1 no stall", bubble_o, 1'b0);
            if (n == 2) chk("R9 regreg flags", {dx_mem_read_o, dx_mem_write_o, dx_reg_write_o}, 3'b001);
            if (n == 3) chk("R9 store flags", {dx_mem_read_o, dx_mem_write_o, dx_reg_write_o}, 3'b010);
            if (n == 4) begin
                chk("R9 load flags", {dx_mem_read_o, dx_mem_write_o, dx_reg_write_o}, 3'b101);
                chk("R9 load dst", dx_rt_o, 5'd8);
            end
        end
    endtask

    // Load into r2 then a use; rs_use selects which field reads r2.
    task automatic t_load_use(input bit rs_use);
        clear_mem();
        imem[0] = ld(5'd2, 5'd1);
        imem[1] = rs_use ? rr(5'd3, 5'd2, 5'd4) : rr(5'd3, 5'd4, 5'd2);
        imem[2] = rr(5'd5, 5'd6, 5'd7);
        do_reset();
        step();
        chk("R1 no early stall", bubble_o, 1'b0);
        step();
        chk(rs_use ? "R1 stall on rs" : "R1 stall on rt", bubble_o, 1'b1);
        chk("R3 pc at stall", pc_o, 32'h8);
        step();
        chk("R4 stall one cycle", bubble_o, 1'b0);
        chk("R3 pc held", pc_o, 32'h8);
        chk("R3 fd held", fd_instr_o, imem[1]);
        chk("R2 zero bundle", {dx_mem_read_o, dx_mem_write_o, dx_reg_write_o}, 3'b000);
        step();
        chk("R6 pc resumes", pc_o, 32'hC);
        chk("R3 use re-decoded into execute", dx_reg_write_o, 1'b1);
        chk("R6 next fetched again", fd_instr_o, imem[2]);
    endtask

    task automatic t_zero_dst();
        int b;
        clear_mem();
        imem[0] = ld(5'd0, 5'd1);
        imem[1] = rr(5'd3, 5'd0, 5'd0);
        do_reset();
        count_bubbles(6, b);
        chk("R5 r0 load no stall", 32'(b), 32'd0);
    endtask

    task automatic t_two_users();
        int b;
        clear_mem();
        imem[0] = ld(5'd2, 5'd1);
        imem[1] = rr(5'd3, 5'd2, 5'd4);
        imem[2] = rr(5'd5, 5'd2, 5'd6);
        do_reset();
        count_bubbles(8, b);
        chk("R8 one stall for two users", 32'(b), 32'd1);
        chk("R8 pc after run", pc_o, 32'(4 * 7));
    endtask

    task automatic t_distance_two();
        int b;
        clear_mem();
        imem[0] = ld(5'd2, 5'd1);
        imem[1] = rr(5'd5, 5'd6, 5'd7);
        imem[2] = rr(5'd3, 5'd2, 5'd4);
        imem[4] = ld(5'd8, 5'd1);
        imem[5] = rr(5'd9, 5'd10, 5'd11);
        do_reset();
        count_bubbles(9, b);
        chk("R1 no stall at distance two or unrelated", 32'(b), 32'd0);
    endtask

    task automatic t_load_chain();
        clear_mem();
        imem[0] = ld(5'd2, 5'd1);
        imem[1] = ld(5'd3, 5'd2);
        imem[2] = rr(5'd4, 5'd3, 5'd5);
        do_reset();
        step(); step();
        chk("R1 chain first stall", bubble_o, 1'b1);
        step();
        chk("R4 chain gap", bubble_o, 1'b0);
        step();
        chk("R1 chain second stall", bubble_o, 1'b1);
        chk("R3 chain pc", pc_o, 32'hC);
        step();
        chk("R3 chain pc held", pc_o, 32'hC);
        chk("R2 chain zero bundle", dx_mem_read_o, 1'b0);
    endtask

    initial begin
        t_reset_state();
        t_no_hazard();
        t_load_use(1'b1);
        t_load_use(1'b0);
        t_zero_dst();
        t_two_users();
        t_distance_two();
        t_load_chain();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule